// File: doc/BRIEF.md
# Mode-Dependent Pixel Serializer with Pen Palette

This block sits between a screen-memory fetch path and the colour output stage of a video pipeline. Every eight dot clocks it takes one byte of pixel data and turns it into eight dot-rate outputs. How a byte breaks into pixels depends on the graphics mode. The two-colour mode gives eight one-bit pixels. The four-colour mode gives four two-bit pixels, each shown for two dots. The sixteen-colour mode gives two four-bit pixels, each shown for four dots. In the last two modes the bits of each pixel are spread across the byte rather than packed side by side.

Each pixel value selects one of sixteen pens. A pen table maps each pen to a 5-bit hardware colour code, which is the low five bits of the 0x40..0x5F code range. The table has one more entry, for the border, which is shown whenever the display-enable flag is low. A fourth mode decodes bytes with the sixteen-colour layout but keeps only the two low pen bits. The upstream fetch logic watches the slot strobe and offers a byte in the cycle the strobe is high.

Top module: `pixel_serializer`

## Requirements
- R1: `slot_o` is high in exactly one cycle out of every eight, and it is high in the first cycle after reset is released. The byte on `byte_i` is taken at the clock edge that ends a cycle in which `slot_o` is high.
- R2: In mode 2 (`mode_i` = 2'd2), dot d (d = 0..7, 0 shown first) uses pen `{000, byte[7-d]}`.
- R3: In mode 1 (`mode_i` = 2'd1), pixel k = d/2 uses pen bit 0 from byte bit 7-k and pen bit 1 from byte bit 3-k. Pen bits 3..2 are zero.
- R4: In mode 0 (`mode_i` = 2'd0), pixel p = d/4 uses pen bits 0,1,2,3 from byte bits 7-p, 3-p, 5-p and 1-p.
- R5: In mode 3 (`mode_i` = 2'd3), the byte is split as in mode 0, but pen bits 3..2 are forced to zero.
- R6: The colour for dot d appears on `color_o` after the clock edge two cycles after the cycle in which that dot is current. Dot 0 is current in the cycle after the byte is taken.
- R7: If `disp_en_i` is low in the cycle a dot is current, that dot is shown with the border entry (index 16) and not with its pen.
- R8: A write with `pal_we_i` high stores `pal_code_i` in entry `pal_idx_i`. Indices 0..15 are pens and 16 is the border. Writes to indices 17..31 change nothing.
- R9: The mode is latched together with the byte. A change of `mode_i` while a byte is being shown does not affect that byte.
- R10: If `byte_valid_i` is low in the slot cycle, the next eight dots all use pen 0.
- R11: After reset, `color_o` is 0 and every table entry holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| byte_valid_i | input | 1 | `byte_i` holds valid screen data |
| byte_i | input | 8 | Screen-memory byte |
| mode_i | input | 2 | Graphics mode, 0..3 |
| disp_en_i | input | 1 | Active display area; when low the border is shown |
| pal_we_i | input | 1 | Write strobe for the pen table |
| pal_idx_i | input | 5 | Table entry to write: 0..15 pens, 16 border |
| pal_code_i | input | COLOR_W | Colour code to store |
| slot_o | output | 1 | Byte acceptance slot |
| color_o | output | COLOR_W | Hardware colour code for the current dot |

## Verification
The bench builds the block with the default 5-bit colour code. With that width the bench can give every pen its own distinct code (pen plus 8) and give the border code 31, so a single output value shows both the decoded pen and whether border substitution happened. The byte patterns are chosen so that every interleave position in modes 0, 1 and 3 shows up as a different pen. This exposes any swapped or misplaced bit.

// File: rtl/pxs_pkg.sv
package pxs_pkg;
    localparam int BYTE_W      = 8;
    localparam int DOT_W       = $clog2(BYTE_W);
    localparam int PEN_W       = 4;
    localparam int NUM_PENS    = 1 << PEN_W;
    localparam int NUM_ENTRIES = NUM_PENS + 1;
    localparam int IDX_W       = $clog2(NUM_ENTRIES);
    localparam int BORDER_IDX  = NUM_PENS;

    typedef enum logic [1:0] {
        PXM_P16  = 2'd0,
        PXM_P4   = 2'd1,
        PXM_P2   = 2'd2,
        PXM_P16M = 2'd3
    } pxs_mode_e;
endpackage

// File: rtl/pxs_pen_decode.sv
module pxs_pen_decode
    import pxs_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [DOT_W-1:0]  dot_i,
    input  pxs_mode_e         mode_i,
    output logic [PEN_W-1:0]  pen_o
);
    logic [DOT_W-1:0] pix4;
    logic [DOT_W-1:0] pix16;

    // pixel index within the byte for the 2-dot and 4-dot pixel modes
    assign pix4  = {1'b0, dot_i[DOT_W-1:1]};
    assign pix16 = {2'b00, dot_i[DOT_W-1]};

    always_comb begin
        pen_o = '0;
        unique case (mode_i)
            PXM_P2: pen_o = {3'b000, byte_i[3'd7 - dot_i]};
            PXM_P4: pen_o = {2'b00, byte_i[3'd3 - pix4], byte_i[3'd7 - pix4]};
            PXM_P16, PXM_P16M: begin
                pen_o = {byte_i[3'd1 - pix16], byte_i[3'd5 - pix16],
                         byte_i[3'd3 - pix16], byte_i[3'd7 - pix16]};
                if (mode_i == PXM_P16M) pen_o[3:2] = 2'b00;
            end
            default: pen_o = '0;
        endcase
    end
endmodule

// File: rtl/pxs_palette.sv
module pxs_palette
    import pxs_pkg::*;
#(
    parameter int COLOR_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we_i,
    input  logic [IDX_W-1:0]   idx_i,
    input  logic [COLOR_W-1:0] code_i,
    input  logic [PEN_W-1:0]   rd_pen_i,
    output logic [COLOR_W-1:0] rd_code_o,
    output logic [COLOR_W-1:0] border_code_o
);
    logic [COLOR_W-1:0] ent_q [NUM_ENTRIES];

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                             ent_q[g] <= '0;
            else if (we_i && idx_i == IDX_W'(g))    ent_q[g] <= code_i;
        end
    end

    assign rd_code_o     = ent_q[{1'b0, rd_pen_i}];
    assign border_code_o = ent_q[BORDER_IDX];
endmodule

// File: rtl/pixel_serializer.sv
module pixel_serializer
    import pxs_pkg::*;
#(
    parameter int COLOR_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               byte_valid_i,
    input  logic [7:0]         byte_i,
    input  logic [1:0]         mode_i,
    input  logic               disp_en_i,
    input  logic               pal_we_i,
    input  logic [4:0]         pal_idx_i,
    input  logic [COLOR_W-1:0] pal_code_i,
    output logic               slot_o,
    output logic [COLOR_W-1:0] color_o
);
    localparam logic [DOT_W-1:0] LAST_DOT = DOT_W'(BYTE_W - 1);

    typedef struct packed {
        logic [DOT_W-1:0]   cnt;
        logic [BYTE_W-1:0]  byt;
        pxs_mode_e          mode;
        logic [PEN_W-1:0]   pen;
        logic               blank;
        logic [COLOR_W-1:0] color;
    } state_t;

    state_t state_d, state_q;

    logic [PEN_W-1:0]   pen_dec;
    logic [COLOR_W-1:0] pen_code;
    logic [COLOR_W-1:0] border_code;
    logic [1:0]         mode_cur;
    logic               take;

    assign take     = (state_q.cnt == LAST_DOT);
    assign mode_cur = state_q.mode;

    pxs_pen_decode u_dec (
        .byte_i (state_q.byt),
        .dot_i  (state_q.cnt),
        .mode_i (state_q.mode),
        .pen_o  (pen_dec)
    );

    pxs_palette #(.COLOR_W(COLOR_W)) u_pal (
        .clk           (clk),
        .rst_n         (rst_n),
        .we_i          (pal_we_i),
        .idx_i         (pal_idx_i),
        .code_i        (pal_code_i),
        .rd_pen_i      (state_q.pen),
        .rd_code_o     (pen_code),
        .border_code_o (border_code)
    );

    always_comb begin
        state_d     = state_q;
        state_d.cnt = state_q.cnt + 1'b1;
        if (take) begin
            state_d.byt  = byte_valid_i ? byte_i : '0;
            state_d.mode = pxs_mode_e'(mode_i);
        end
        state_d.pen   = pen_dec;
        state_d.blank = !disp_en_i;
        state_d.color = state_q.blank ? border_code : pen_code;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.cnt   <= LAST_DOT;
            state_q.byt   <= '0;
            state_q.mode  <= PXM_P16;
            state_q.pen   <= '0;
            state_q.blank <= 1'b1;
            state_q.color <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign slot_o  = take;
    assign color_o = state_q.color;
endmodule

// File: rtl/pixel_serializer_chk.sv
module pixel_serializer_chk #(
    parameter int COLOR_W = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               slot_o,
    input logic               disp_en_i,
    input logic               pal_we_i,
    input logic [4:0]         pal_idx_i,
    input logic [COLOR_W-1:0] pal_code_i,
    input logic [COLOR_W-1:0] color_o,
    input logic [1:0]         mode_cur,
    input logic [3:0]         pen_dec
);
    logic [2:0]         gap_q;
    logic               seen_q;
    logic [1:0]         age_q;
    logic [COLOR_W-1:0] brd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
            age_q  <= '0;
            brd_q  <= '0;
        end else begin
            gap_q  <= slot_o ? 3'd0 : gap_q + 1'b1;
            seen_q <= seen_q | slot_o;
            if (age_q != 2'd3) age_q <= age_q + 1'b1;
            if (pal_we_i && pal_idx_i == 5'd16) brd_q <= pal_code_i;
        end
    end

    assert_slot_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        slot_o |=> !slot_o);

    assert_slot_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_o && seen_q) |-> gap_q == 3'd7);

    assert_hires_pen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_cur == 2'd2) |-> pen_dec <= 4'd1);

    assert_medres_pen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_cur == 2'd1) |-> pen_dec <= 4'd3);

    assert_masked_pen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_cur == 2'd3) |-> pen_dec[3:2] == 2'b00);

    assert_border_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3 && !$past(disp_en_i, 2) && !$past(pal_we_i)) |-> color_o == brd_q);
endmodule

bind pixel_serializer pixel_serializer_chk #(.COLOR_W(COLOR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_o     (slot_o),
    .disp_en_i  (disp_en_i),
    .pal_we_i   (pal_we_i),
    .pal_idx_i  (pal_idx_i),
    .pal_code_i (pal_code_i),
    .color_o    (color_o),
    .mode_cur   (mode_cur),
    .pen_dec    (pen_dec)
);

// File: tb/pixel_serializer_bench.sv
module pixel_serializer_bench;
    localparam int COLOR_W = 5;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               byte_valid_i = 1'b0;
    logic [7:0]         byte_i = '0;
    logic [1:0]         mode_i = 2'd2;
    logic               disp_en_i = 1'b1;
    logic               pal_we_i = 1'b0;
    logic [4:0]         pal_idx_i = '0;
    logic [COLOR_W-1:0] pal_code_i = '0;
    logic               slot_o;
    logic [COLOR_W-1:0] color_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pixel_serializer #(.COLOR_W(COLOR_W)) u_pixel_serializer (
        .clk(clk), .rst_n(rst_n), .byte_valid_i(byte_valid_i), .byte_i(byte_i),
        .mode_i(mode_i), .disp_en_i(disp_en_i), .pal_we_i(pal_we_i),
        .pal_idx_i(pal_idx_i), .pal_code_i(pal_code_i),
        .slot_o(slot_o), .color_o(color_o)
    );

    typedef struct packed {
        logic [1:0]  m;
        logic [7:0]  b;
        logic [31:0] pens;   // dot 0 in the top nibble
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{2'd2, 8'hA5, 32'h10100101, 4'd2},  // R2
        '{2'd2, 8'h81, 32'h10000001, 4'd2},  // R2
        '{2'd1, 8'hF0, 32'h11111111, 4'd3},  // R3
        '{2'd1, 8'h1E, 32'h22222211, 4'd3},  // R3
        '{2'd1, 8'h84, 32'h11220000, 4'd3},  // R3
        '{2'd0, 8'h80, 32'h11110000, 4'd4},  // R4
        '{2'd0, 8'h5A, 32'hAAAA5555, 4'd4},  // R4
        '{2'd0, 8'hFF, 32'hFFFFFFFF, 4'd4},  // R4
        '{2'd3, 8'hFF, 32'h33333333, 4'd5},  // R5
        '{2'd3, 8'h5A, 32'h22221111, 4'd5}   // R5
    };

    task automatic chk(input logic [COLOR_W-1:0] act, input logic [COLOR_W-1:0] exp, input int req);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL R%0d actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_slot();
        @(negedge clk);
        while (!slot_o) @(negedge clk);
    endtask

    task automatic pal_write(input logic [4:0] idx, input logic [COLOR_W-1:0] code);
        @(negedge clk);
        pal_we_i = 1'b1; pal_idx_i = idx; pal_code_i = code;
        @(negedge clk);
        pal_we_i = 1'b0;
    endtask

    // one byte, eight dots checked; expected colour is pen+8 or a fixed code
    task automatic run_byte(input logic [1:0] m, input logic [7:0] b, input logic [1:0] m2,
                            input logic vld, input logic [31:0] pens,
                            input bit fixed, input logic [COLOR_W-1:0] fcode, input int req);
        wait_slot();
        byte_valid_i = vld; byte_i = b; mode_i = m;
        for (int j = 0; j < 10; j++) begin
            @(negedge clk);
            if (j == 0) begin byte_valid_i = 1'b0; mode_i = m2; end
            if (j >= 2) begin
                logic [3:0] p;
                p = pens[31 - 4*(j-2) -: 4];
                chk(color_o, fixed ? fcode : COLOR_W'(p) + COLOR_W'(8), req);
            end
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state, R1 slot right after release
        chk(color_o, '0, 11);
        rst_n = 1'b1;
        chk(COLOR_W'(slot_o), COLOR_W'(1), 1);
        @(negedge clk);
        chk(color_o, '0, 11);

        // R1 slot period of eight
        begin
            int n;
            wait_slot();
            n = 0;
            do begin @(negedge clk); n++; end while (!slot_o && n < 20);
            chk(COLOR_W'(n), COLOR_W'(8), 1);
        end

        for (int i = 0; i < 16; i++) pal_write(5'(i), COLOR_W'(i + 8));
        pal_write(5'd16, COLOR_W'(31));

        foreach (VECS[i])
            run_byte(VECS[i].m, VECS[i].b, VECS[i].m, 1'b1, VECS[i].pens, 1'b0, '0, int'(VECS[i].req));

        // R6 latency: dot 0 of 0x80 in mode 2 appears two edges after it is current
        wait_slot();
        byte_valid_i = 1'b1; byte_i = 8'h80; mode_i = 2'd2;
        @(negedge clk); byte_valid_i = 1'b0;
        @(negedge clk); chk(color_o, COLOR_W'(8), 6);
        @(negedge clk); chk(color_o, COLOR_W'(9), 6);
        @(negedge clk); chk(color_o, COLOR_W'(8), 6);

        // R9 mode change mid-byte is ignored
        run_byte(2'd1, 8'hF0, 2'd0, 1'b1, 32'h11111111, 1'b0, '0, 9);

        // R7 border while display disabled
        disp_en_i = 1'b0;
        run_byte(2'd2, 8'hFF, 2'd2, 1'b1, 32'h0, 1'b1, COLOR_W'(31), 7);
        disp_en_i = 1'b1;

        // R8 out-of-range index writes are ignored, border and pens unchanged
        pal_write(5'd17, COLOR_W'(3));
        pal_write(5'd31, COLOR_W'(4));
        disp_en_i = 1'b0;
        run_byte(2'd2, 8'hFF, 2'd2, 1'b1, 32'h0, 1'b1, COLOR_W'(31), 8);
        disp_en_i = 1'b1;
        run_byte(2'd2, 8'hFF, 2'd2, 1'b1, 32'h11111111, 1'b0, '0, 8);

        // R8 pen rewrite takes effect, R10 missing byte shows pen 0
        pal_write(5'd0, COLOR_W'(2));
        run_byte(2'd0, 8'hFF, 2'd0, 1'b0, 32'h0, 1'b1, COLOR_W'(2), 10);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule